// File: doc/BRIEF.md
# Trap return status update unit

This block executes the two trap-return operations of a hart: the machine-level return and the supervisor-level return. It keeps the privilege-related status bits, the current privilege level, the virtualization flag and the two saved exception PCs. When a return is requested it first decides whether the return is legal. If the return is legal, it restores the interrupt-enable and previous-mode bits, moves the hart to its new privilege and virtualization state, and reports the PC to resume at. If the return is not legal, it reports an exception code and leaves all state untouched.

A trap-entry path or a state-restore sequence writes the whole status word and both exception PCs through a single load port. The pipeline raises `ret_req` for one cycle, together with the return type. The answer arrives one cycle later as a single-cycle `ret_done` pulse.

Top module: `trp_ret_unit`

## Requirements
- R1: After reset the privilege field is M (code 3), every other status bit is 0, and `ret_done` is low.
- R2: When `ld_en` is high, the next clock edge writes `ld_stat` and both PCs into the state. A return request in the same cycle is ignored and produces no `ret_done`. The status word has this layout: [0] machine IE, [1] machine previous IE, [3:2] machine previous mode, [4] machine previous virt, [5] modify-privilege, [6] supervisor IE, [7] supervisor previous IE, [8] supervisor previous mode, [9] supervisor previous virt, [10] trap-sret, [11] virtual trap-sret, [13:12] privilege (U=0, S=1, M=3), [14] virtualization.
- R3: An accepted request gives a `ret_done` pulse exactly one cycle later. On success, `ret_pc` is the selected exception PC with bit 0 cleared. On an exception, `ret_pc` is 0. `ret_kind` 0 selects the machine return and 1 selects the supervisor return.
- R4: A machine return below M raises illegal instruction (code 2). Otherwise, when compressed support is absent and bit 1 of the saved machine PC is set, it raises address-misaligned (code 0).
- R5: A supervisor return checks its conditions in this order:
  1. Privilege U gives code 2.
  2. Misaligned saved supervisor PC (no compressed support) gives code 0.
  3. Trap-sret set while below M gives code 2.
  4. Virtualization on with virtual trap-sret set gives code 22.
- R6: A successful machine return copies the previous machine IE into machine IE, sets previous IE to 1, and sets previous mode to U (to M when U is absent). It also clears previous virt.
- R7: A successful machine return sets privilege to the old previous mode. It sets virtualization to old previous virt AND (old previous mode != M). It clears modify-privilege only when the old previous mode is not M.
- R8: A successful supervisor return copies the previous supervisor IE into supervisor IE and sets previous IE to 1. It sets privilege to the old supervisor previous mode and then clears that bit. It also clears modify-privilege.
- R9: With hypervisor support and virtualization off, a successful supervisor return takes virtualization from the supervisor previous virt bit and clears that bit. With virtualization on, both stay unchanged.
- R10: A return that raises an exception changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load status word and exception PCs |
| ld_stat | input | 15 | Status word to load (layout in R2) |
| ld_mepc | input | XLEN | Machine exception PC to load |
| ld_sepc | input | XLEN | Supervisor exception PC to load |
| ret_req | input | 1 | Return request |
| ret_kind | input | 1 | 0 machine return, 1 supervisor return |
| ret_done | output | 1 | One-cycle completion pulse |
| ret_fault | output | 1 | Return raised an exception |
| ret_code | output | 5 | Exception code when `ret_fault` |
| ret_pc | output | XLEN | Resume PC on success |
| cur_stat | output | 15 | Current status word |

## Verification
The bench builds the unit with XLEN 32, user mode present, hypervisor support present and compressed support absent. The absent compressed support makes the misaligned-PC exception reachable. Hypervisor support makes the previous-virt paths of both returns observable. The bench sweeps both return types over every legal privilege/virtualization pair and every combination of previous modes, enable bits, trap-sret bits and low PC bits. This exposes each step of the check ordering and each conditional clear.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic       RET_M  = 1'b0;
    localparam logic       RET_S  = 1'b1;

    localparam int         CODE_W = 5;
    localparam logic [CODE_W-1:0] EXC_MISALIGN = 5'd0;
    localparam logic [CODE_W-1:0] EXC_ILLEGAL  = 5'd2;
    localparam logic [CODE_W-1:0] EXC_VIRT     = 5'd22;

    // LSB first: mie at bit 0 ... virt at bit 14
    typedef struct packed {
        logic       virt;
        logic [1:0] priv;
        logic       vtsr;
        logic       tsr;
        logic       spv;
        logic       spp;
        logic       spie;
        logic       sie;
        logic       mprv;
        logic       mpv;
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
    } hart_stat_t;

    localparam int STAT_W = $bits(hart_stat_t);

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
    } verdict_t;

endpackage

// File: rtl/trp_pc_sel.sv
module trp_pc_sel #(
    parameter int XLEN = 32
) (
    input  logic            kind,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] pc_out,
    output logic            pc_bit1
);
    import trp_pkg::*;

    logic [XLEN-1:0] epc_sel;

    always_comb begin
        epc_sel = (kind == RET_S) ? sepc : mepc;
        pc_out  = {epc_sel[XLEN-1:1], 1'b0};
        pc_bit1 = epc_sel[1];
    end
endmodule

// File: rtl/trp_check.sv
module trp_check #(
    parameter bit HAS_C = 1'b1
) (
    input  logic                kind,
    input  trp_pkg::hart_stat_t stat,
    input  logic                pc_bit1,
    output trp_pkg::verdict_t   verdict
);
    import trp_pkg::*;

    logic misal;

    generate
        if (HAS_C) begin : g_cmp
            assign misal = 1'b0;
            logic unused_bit;
            assign unused_bit = pc_bit1;
        end else begin : g_nocmp
            assign misal = pc_bit1;
        end
    endgenerate

    always_comb begin
        verdict = '0;
        if (kind == RET_M) begin
            if (stat.priv != PRIV_M) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_ILLEGAL;
            end else if (misal) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_MISALIGN;
            end
        end else begin
            if (stat.priv < PRIV_S) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_ILLEGAL;
            end else if (misal) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_MISALIGN;
            end else if (stat.tsr && (stat.priv != PRIV_M)) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_ILLEGAL;
            end else if (stat.virt && stat.vtsr) begin
                verdict.fault = 1'b1;
                verdict.code  = EXC_VIRT;
            end
        end
    end
endmodule

// File: rtl/trp_update.sv
module trp_update #(
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_H = 1'b1
) (
    input  logic                kind,
    input  trp_pkg::hart_stat_t stat,
    output trp_pkg::hart_stat_t stat_new
);
    import trp_pkg::*;

    localparam logic [1:0] MPP_AFTER = HAS_U ? PRIV_U : PRIV_M;

    always_comb begin
        stat_new = stat;
        if (kind == RET_M) begin
            stat_new.mie  = stat.mpie;
            stat_new.mpie = 1'b1;
            stat_new.mpp  = MPP_AFTER;
            stat_new.mpv  = 1'b0;
            stat_new.priv = stat.mpp;
            stat_new.virt = HAS_H && stat.mpv && (stat.mpp != PRIV_M);
            if (stat.mpp != PRIV_M) begin
                stat_new.mprv = 1'b0;
            end
        end else begin
            stat_new.sie  = stat.spie;
            stat_new.spie = 1'b1;
            stat_new.spp  = 1'b0;
            stat_new.mprv = 1'b0;
            stat_new.priv = {1'b0, stat.spp};
            if (HAS_H && !stat.virt) begin
                stat_new.virt = stat.spv;
                stat_new.spv  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/trp_ret_unit.sv
module trp_ret_unit
    import trp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_H = 1'b1,
    parameter bit HAS_C = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [14:0]       ld_stat,
    input  logic [XLEN-1:0]   ld_mepc,
    input  logic [XLEN-1:0]   ld_sepc,
    input  logic              ret_req,
    input  logic              ret_kind,
    output logic              ret_done,
    output logic              ret_fault,
    output logic [4:0]        ret_code,
    output logic [XLEN-1:0]   ret_pc,
    output logic [14:0]       cur_stat
);

    typedef struct packed {
        hart_stat_t        stat;
        logic [XLEN-1:0]   mepc;
        logic [XLEN-1:0]   sepc;
        logic              done;
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   pc;
    } unit_state_t;

    unit_state_t st_d, st_q;
    hart_stat_t  ld_legal;
    hart_stat_t  upd_stat;
    verdict_t    verdict;
    logic [XLEN-1:0] sel_pc;
    logic        sel_bit1;

    // load legalisation: without hypervisor support no virt bit may be set
    generate
        if (HAS_H) begin : g_hyp
            assign ld_legal = hart_stat_t'(ld_stat);
        end else begin : g_nohyp
            hart_stat_t raw;
            always_comb begin
                raw       = hart_stat_t'(ld_stat);
                ld_legal  = raw;
                ld_legal.virt = 1'b0;
                ld_legal.spv  = 1'b0;
                ld_legal.mpv  = 1'b0;
            end
        end
    endgenerate

    trp_pc_sel #(.XLEN(XLEN)) u_pc (
        .kind    (ret_kind),
        .mepc    (st_q.mepc),
        .sepc    (st_q.sepc),
        .pc_out  (sel_pc),
        .pc_bit1 (sel_bit1)
    );

    trp_check #(.HAS_C(HAS_C)) u_chk (
        .kind    (ret_kind),
        .stat    (st_q.stat),
        .pc_bit1 (sel_bit1),
        .verdict (verdict)
    );

    trp_update #(.HAS_U(HAS_U), .HAS_H(HAS_H)) u_upd (
        .kind     (ret_kind),
        .stat     (st_q.stat),
        .stat_new (upd_stat)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        st_d.code  = '0;
        st_d.pc    = '0;
        if (ld_en) begin
            st_d.stat = ld_legal;
            st_d.mepc = ld_mepc;
            st_d.sepc = ld_sepc;
        end else if (ret_req) begin
            st_d.done  = 1'b1;
            st_d.fault = verdict.fault;
            st_d.code  = verdict.code;
            if (!verdict.fault) begin
                st_d.stat = upd_stat;
                st_d.pc   = sel_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.stat.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign ret_done  = st_q.done;
    assign ret_fault = st_q.fault;
    assign ret_code  = st_q.code;
    assign ret_pc    = st_q.pc;
    assign cur_stat  = st_q.stat;

    // ---------------- assertions ----------------
    hart_stat_t cs;
    assign cs = hart_stat_t'(cur_stat);

    p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ld_en) |-> !ret_done);

    p_done_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> $past(ret_req && !ld_en));

    p_fault_in_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fault |-> ret_done);

    p_pc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> !ret_pc[0]);

    p_mret_below_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && $past(ret_kind == RET_M && cs.priv != PRIV_M))
        |-> (ret_fault && ret_code == EXC_ILLEGAL));

    p_mret_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !ret_fault && $past(ret_kind == RET_M))
        |-> (cs.mpie && !cs.mpv));

    p_sret_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !ret_fault && $past(ret_kind == RET_S))
        |-> (cs.spie && !cs.spp && !cs.mprv && cs.priv != PRIV_M));

    p_fault_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && ret_fault) |-> $stable(cur_stat));

endmodule

// File: tb/sim_trp_ret_unit.sv
module sim_trp_ret_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [14:0] ld_stat = '0;
    logic [31:0] ld_mepc = '0;
    logic [31:0] ld_sepc = '0;
    logic        ret_req = 1'b0;
    logic        ret_kind = 1'b0;
    logic        ret_done;
    logic        ret_fault;
    logic [4:0]  ret_code;
    logic [31:0] ret_pc;
    logic [14:0] cur_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trp_ret_unit #(.XLEN(32), .HAS_U(1'b1), .HAS_H(1'b1), .HAS_C(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_stat(ld_stat),
        .ld_mepc(ld_mepc), .ld_sepc(ld_sepc), .ret_req(ret_req),
        .ret_kind(ret_kind), .ret_done(ret_done), .ret_fault(ret_fault),
        .ret_code(ret_code), .ret_pc(ret_pc), .cur_stat(cur_stat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] mk(input logic virt, input logic [1:0] priv,
        input logic vtsr, input logic tsr, input logic spv, input logic spp,
        input logic spie, input logic sie, input logic mprv, input logic mpv,
        input logic [1:0] mpp, input logic mpie, input logic mie);
        return {virt, priv, vtsr, tsr, spv, spp, spie, sie, mprv, mpv, mpp, mpie, mie};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset stat", {17'd0, cur_stat}, 32'h3000);
        chk("R1 reset done", {31'd0, ret_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 load wins over a same-cycle request; R3 pulse width
        ld_en = 1'b1; ld_stat = 15'h1ABC; ld_mepc = 32'h100; ld_sepc = 32'h200;
        ret_req = 1'b1; ret_kind = 1'b0;
        @(negedge clk);
        ld_en = 1'b0; ret_req = 1'b0;
        chk("R2 load stat", {17'd0, cur_stat}, 32'h1ABC);
        chk("R2 request ignored", {31'd0, ret_done}, 32'd0);
        ld_en = 1'b1; ld_stat = mk(0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 1, 0);
        ld_mepc = 32'h0000_0F01;
        @(negedge clk);
        ld_en = 1'b0; ret_req = 1'b1; ret_kind = 1'b0;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R3 done pulse", {31'd0, ret_done}, 32'd1);
        chk("R3 pc bit0 cleared", ret_pc, 32'h0000_0F00);
        @(negedge clk);
        chk("R3 single pulse", {31'd0, ret_done}, 32'd0);

        // sweep: R4..R10
        for (int k = 0; k < 2; k++)
        for (int pi = 0; pi < 3; pi++)
        for (int v = 0; v < 2; v++)
        for (int mi = 0; mi < 3; mi++)
        for (int bits = 0; bits < 128; bits++)
        for (int low = 0; low < 4; low++) begin
            logic [1:0] p, mpp_v;
            logic mpv, mpie, spp, spie, spv, tsr, vtsr, mprv, virt;
            logic [31:0] mepc, sepc, epc;
            logic fault_e; logic [4:0] code_e; logic [14:0] st_e, st_in;
            logic [31:0] pc_e;
            p     = (pi == 2) ? 2'd3 : 2'(pi);
            virt  = v[0];
            if (!(p == 2'd3 && virt)) begin
                mpp_v = (mi == 2) ? 2'd3 : 2'(mi);
                mpv  = bits[0]; mpie = bits[1]; spp = bits[2]; spie = bits[3];
                spv  = bits[4]; tsr = bits[5]; vtsr = bits[6];
                mprv = ~low[0];
                mepc = 32'h8000_1000 | 32'(low);
                sepc = 32'h4000_2000 | 32'(low);
                st_in = mk(virt, p, vtsr, tsr, spv, spp, spie, ~spie, mprv, mpv,
                           mpp_v, mpie, ~mpie);
                epc = k[0] ? sepc : mepc;
                fault_e = 1'b0; code_e = 5'd0;
                if (k == 0) begin
                    if (p != 2'd3) begin fault_e = 1; code_e = 5'd2; end
                    else if (epc[1]) begin fault_e = 1; code_e = 5'd0; end
                end else begin
                    if (p == 2'd0) begin fault_e = 1; code_e = 5'd2; end
                    else if (epc[1]) begin fault_e = 1; code_e = 5'd0; end
                    else if (tsr && p != 2'd3) begin fault_e = 1; code_e = 5'd2; end
                    else if (virt && vtsr) begin fault_e = 1; code_e = 5'd22; end
                end
                if (fault_e) begin
                    st_e = st_in; pc_e = 32'd0;
                end else if (k == 0) begin
                    st_e = mk(mpv && (mpp_v != 2'd3), mpp_v, vtsr, tsr, spv, spp, spie,
                              ~spie, (mpp_v == 2'd3) ? mprv : 1'b0, 1'b0, 2'd0, 1'b1, mpie);
                    pc_e = epc & ~32'd1;
                end else begin
                    st_e = mk(virt ? 1'b1 : spv, {1'b0, spp}, vtsr, tsr,
                              virt ? spv : 1'b0, 1'b0, 1'b1, spie, 1'b0, mpv,
                              mpp_v, mpie, ~mpie);
                    pc_e = epc & ~32'd1;
                end
                ld_en = 1'b1; ld_stat = st_in; ld_mepc = mepc; ld_sepc = sepc;
                @(negedge clk);
                ld_en = 1'b0; ret_req = 1'b1; ret_kind = k[0];
                @(negedge clk);
                ret_req = 1'b0;
                chk("R3 done", {31'd0, ret_done}, 32'd1);
                chk(k == 0 ? "R4 verdict" : "R5 verdict",
                    {26'd0, ret_fault, ret_code}, {26'd0, fault_e, code_e});
                chk("R3 pc", ret_pc, pc_e);
                chk(fault_e ? "R10 state kept" :
                    (k == 0 ? "R6 R7 machine update" : "R8 R9 supervisor update"),
                    {17'd0, cur_stat}, {17'd0, st_e});
            end
        end
        finish_run();
    end

endmodule